// File: doc/BRIEF.md
# 32-bit Integer ALU with Signed Compare

This is a purely combinational arithmetic logic unit for the execute stage of a small load/store processor. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result, a flag that marks an all-zero result, and a flag that marks signed overflow. The ALU has no clock and no state. A result is valid as soon as the inputs settle. The surrounding pipeline registers capture the result.

Addition and subtraction share one carry chain of per-bit slices. To subtract, the unit inverts operand B and forces the carry into bit 0 to one. The most significant slice is built differently: it also produces the overflow condition and the signed less-than bit. For set-less-than, the unit XORs the sign of A minus B with the overflow of that subtraction, so the compare stays correct at the extremes of the range. The unit places that single bit in bit 0 of the result. A branch-on-equal decision uses the zero flag after a subtraction. Shifts, multiply, divide and the decoder that produces the operation code live elsewhere.

Top module: `alu32`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of A and B.
- R2: Code 4'b0001 returns the bitwise OR of A and B.
- R3: Code 4'b1100 returns the bitwise NOR of A and B.
- R4: Code 4'b0010 returns A plus B modulo 2^32.
- R5: Code 4'b0110 returns A minus B modulo 2^32, formed by inverting B and adding with a carry-in of one.
- R6: Code 4'b0111 returns 1 in bit 0 when A is less than B as signed two's-complement numbers, otherwise 0. Bits 31 down to 1 are always 0. The compare is correct even when A minus B overflows.
- R7: The zero flag is 1 exactly when all 32 result bits are 0, for every operation code.
- R8: Under code 4'b0010, the overflow flag is 1 exactly when A and B have the same sign bit and the sign bit of the sum differs from it.
- R9: Under code 4'b0110, the overflow flag is 1 exactly when A and B have different sign bits and the sign bit of the difference differs from the sign bit of A.
- R10: Under codes 4'b0000, 4'b0001, 4'b1100 and 4'b0111, the overflow flag is 0.
- R11: Any code not listed in R1 to R6 gives a result of zero and an overflow flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B) |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
Every output is due in the same cycle as its inputs, with no register between them. The bench applies each operand pair and code on the falling clock edge. It compares all three outputs against its reference one time unit later, well before the next rising edge, so every input change is checked once after it has settled. The corner operands 0, -1, 1, the most negative value and the most positive value are paired with each other under all sixteen codes. Random pairs then run under all sixteen codes. This covers the overflowing compares and the unused codes.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OPC_AND = 4'b0000;
  localparam logic [OP_W-1:0] OPC_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OPC_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OPC_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OPC_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OPC_NOR = 4'b1100;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_NOR,
    SEL_SUM,
    SEL_LESS,
    SEL_NONE
  } res_sel_e;

  typedef struct packed {
    res_sel_e sel;
    logic     invert_b;
    logic     arith;
  } alu_ctl_t;

  function automatic alu_ctl_t decode_op(input logic [OP_W-1:0] code);
    alu_ctl_t c;
    c = '{sel: SEL_NONE, invert_b: 1'b0, arith: 1'b0};
    case (code)
      OPC_AND: c.sel = SEL_AND;
      OPC_OR:  c.sel = SEL_OR;
      OPC_NOR: c.sel = SEL_NOR;
      OPC_ADD: begin c.sel = SEL_SUM;  c.arith = 1'b1; end
      OPC_SUB: begin c.sel = SEL_SUM;  c.arith = 1'b1; c.invert_b = 1'b1; end
      OPC_SLT: begin c.sel = SEL_LESS; c.invert_b = 1'b1; end
      default: c.sel = SEL_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/alu_slice.sv
module alu_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic inv_b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o,
  output logic and_o,
  output logic or_o
);
  logic b_eff;

  always_comb begin
    b_eff  = b_i ^ inv_b_i;
    sum_o  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (cin_i & (a_i ^ b_eff));
    and_o  = a_i & b_i;
    or_o   = a_i | b_i;
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic inv_b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic and_o,
  output logic or_o,
  output logic ovf_o,
  output logic less_o
);
  logic b_eff;

  always_comb begin
    b_eff  = b_i ^ inv_b_i;
    sum_o  = a_i ^ b_eff ^ cin_i;
    and_o  = a_i & b_i;
    or_o   = a_i | b_i;
    // same effective operand signs, sum sign flipped away from them
    ovf_o  = ~(a_i ^ b_eff) & (sum_o ^ a_i);
    // sign of the difference, corrected when the subtraction overflows
    less_o = sum_o ^ ovf_o;
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);
  assign zero_o = ~(|value_i);
endmodule

// File: rtl/alu32.sv
module alu32 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]             opa_i,
  input  logic [WIDTH-1:0]             opb_i,
  input  logic [alu32_pkg::OP_W-1:0]   op_i,
  output logic [WIDTH-1:0]             res_o,
  output logic                         zero_o,
  output logic                         ovf_o
);
  import alu32_pkg::*;

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] sum_v;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [MSB:0]     carry;
  logic             ovf_raw;
  logic             less_bit;

  assign ctl      = decode_op(op_i);
  assign carry[0] = ctl.invert_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < MSB) begin : g_low
      alu_slice u_slice (
        .a_i    (opa_i[i]),
        .b_i    (opb_i[i]),
        .inv_b_i(ctl.invert_b),
        .cin_i  (carry[i]),
        .sum_o  (sum_v[i]),
        .cout_o (carry[i+1]),
        .and_o  (and_v[i]),
        .or_o   (or_v[i])
      );
    end else begin : g_top
      alu_msb_slice u_slice (
        .a_i    (opa_i[i]),
        .b_i    (opb_i[i]),
        .inv_b_i(ctl.invert_b),
        .cin_i  (carry[i]),
        .sum_o  (sum_v[i]),
        .and_o  (and_v[i]),
        .or_o   (or_v[i]),
        .ovf_o  (ovf_raw),
        .less_o (less_bit)
      );
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_AND:  res_o = and_v;
      SEL_OR:   res_o = or_v;
      SEL_NOR:  res_o = ~or_v;
      SEL_SUM:  res_o = sum_v;
      SEL_LESS: res_o = {{MSB{1'b0}}, less_bit};
      default:  res_o = '0;
    endcase
  end

  assign ovf_o = ovf_raw & ctl.arith;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value_i(res_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             ovf_o
);
  logic known;
  always_comb known = !$isunknown({opa_i, opb_i, op_i});

  always_comb begin
    if (known) begin
      // R7
      zero_flag_chk: assert (zero_o == (res_o == '0));
      // R6
      slt_upper_chk: assert (op_i != 4'b0111 || res_o[WIDTH-1:1] == '0);
      // R10
      logic_no_ovf_chk: assert (!(op_i inside {4'b0000, 4'b0001, 4'b1100, 4'b0111}) || !ovf_o);
      // R11
      unused_quiet_chk: assert ((op_i inside {4'b0000, 4'b0001, 4'b1100, 4'b0111, 4'b0010, 4'b0110})
                                || (res_o == '0 && !ovf_o));
      // R8
      add_ovf_sign_chk: assert (!(op_i == 4'b0010 && ovf_o) || (opa_i[WIDTH-1] == opb_i[WIDTH-1]));
      // R9
      sub_ovf_sign_chk: assert (!(op_i == 4'b0110 && ovf_o) || (opa_i[WIDTH-1] != opb_i[WIDTH-1]));
      // R1
      and_subset_chk: assert (op_i != 4'b0000 || (res_o & ~opa_i) == '0);
    end
  end
endmodule

bind alu32 alu32_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i (opa_i),
  .opb_i (opb_i),
  .op_i  (op_i),
  .res_o (res_o),
  .zero_o(zero_o),
  .ovf_o (ovf_o)
);

// File: tb/alu32_tb.sv
module alu32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zero, ovf;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu32 u_dut (
    .opa_i (a),
    .opb_i (b),
    .op_i  (op),
    .res_o (res),
    .zero_o(zero),
    .ovf_o (ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] va, input logic [31:0] vb, input logic [3:0] vop);
    longint      sa, sb;
    logic [31:0] e_res;
    logic        e_ovf;
    string       rtag, otag;
    @(negedge clk);
    a = va; b = vb; op = vop;
    #1;
    sa = longint'($signed(va));
    sb = longint'($signed(vb));
    e_ovf = 1'b0;
    case (vop)
      4'b0000: begin e_res = va & vb;    rtag = "R1"; otag = "R10"; end
      4'b0001: begin e_res = va | vb;    rtag = "R2"; otag = "R10"; end
      4'b1100: begin e_res = ~(va | vb); rtag = "R3"; otag = "R10"; end
      4'b0010: begin
        e_res = 32'(sa + sb);
        e_ovf = (sa + sb > 64'sd2147483647) || (sa + sb < -64'sd2147483648);
        rtag = "R4"; otag = "R8";
      end
      4'b0110: begin
        e_res = 32'(sa - sb);
        e_ovf = (sa - sb > 64'sd2147483647) || (sa - sb < -64'sd2147483648);
        rtag = "R5"; otag = "R9";
      end
      4'b0111: begin e_res = (sa < sb) ? 32'd1 : 32'd0; rtag = "R6"; otag = "R10"; end
      default: begin e_res = 32'd0; rtag = "R11"; otag = "R11"; end
    endcase
    check(rtag, res, e_res);
    check(otag, {31'd0, ovf}, {31'd0, e_ovf});
    check("R7", {31'd0, zero}, {31'd0, (e_res == 32'd0)});
  endtask

  logic [31:0] corner [5] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001,
                              32'h8000_0000, 32'h7FFF_FFFF};

  initial begin
    a = '0; b = '0; op = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // state with neutral inputs while reset held: R1 result zero, R7 flag set
    check("R1", res, 32'd0);
    check("R7", {31'd0, zero}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 16; k++)
          apply(corner[i], corner[j], 4'(k));

    // equal operands: subtract gives zero, R5 and R7
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // overflowing compare: -2^31 < 1 must still be true, R6
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);

    for (int n = 0; n < 200; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      for (int k = 0; k < 16; k++) apply(ra, rb, 4'(k));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule